// File: doc/BRIEF.md
# Dual Match Timer with Toggle Outputs and Input Capture

The block holds two up-counting timer lanes. Each lane counts enable pulses from a clock source that it picks itself. When the count equals the lane's compare value, the counter returns to zero on that same tick. The lane's output pin then flips, and a one-cycle match interrupt pulse follows. Software writes a start bit to clear a lane and launch it. The output begins at a level that software has chosen, so the lane gives a square wave whose half period is the compare value plus one tick.

A cascade setting joins the two lanes into one 16-bit counter. This counter is driven by lane A's clock choice, compares against the pair {high data, low data}, and drives lane A's output and interrupt. Lane B stays idle while cascade is set. Only in cascade mode can a selected edge on the capture pin copy the running 16-bit count into a capture register and raise a capture interrupt. Writes to a data register go into a shadow copy. The lane loads that copy only at start or at a match, so a period already under way keeps its length.

Each lane has a two-state controller. LN_IDLE holds the count. A start write moves it to LN_RUN; a start write in LN_RUN restarts the lane and keeps it in LN_RUN. A stop write returns it to LN_IDLE. Registers (3-bit address): 0 control (bit0 cascade, bit1 lane A initial level, bit2 lane B initial level); 1 clock select (bits 2:0 lane A, bits 5:3 lane B); 2 edge modes (bits 1:0 event input, bits 3:2 capture pin); 3 low data; 4 high data; 5 run (bit0 lane A, bit1 lane B).

Top module: `mtimer_core`

## Requirements
- R1: After reset both outputs are low, no interrupt is asserted and the capture value is zero.
- R2: A running lane with compare value D and a tick on every cycle counts 0..D and clears to zero on the tick where the count equals D, so matches are D+1 ticks apart (D=0 matches on every tick).
- R3: The match interrupt is a pulse in the cycle after the clock edge on which the match clears the counter.
- R4: Each match inverts the lane's output, and this repeats every period.
- R5: Writing 1 to a lane's run bit loads the output with that lane's initial-level bit (1 = high).
- R6: Writing 1 to a run bit clears the count and starts the lane. Writing 0 stops it, and while stopped the output and count hold and no interrupt occurs.
- R7: Clock select code n picks tick input n. For lane A, code 7 picks edges of the event pin instead. A pin change seen at clock edge k advances the count at edge k+2.
- R8: The 2-bit edge mode selects rising (00), falling (01) or both edges (1x), for the event pin and the capture pin alike; edges that are not selected have no effect.
- R9: With cascade set, lane A counts 16 bits against {high data, low data}. Lane B raises no interrupt, and its output holds.
- R10: In cascade mode, a selected capture edge seen at clock edge k stores the count held before edge k+2 into the capture value and pulses the capture interrupt in the following cycle. With cascade clear, the capture pin is ignored.
- R11: A data write during a run takes effect at the next match. The period in progress ends on the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| tick_in | input | 8 | Prescaler clock-enable taps |
| evt_pin | input | 1 | External event input (lane A code 7) |
| cap_pin | input | 1 | Capture trigger input |
| tout_a | output | 1 | Lane A toggle output |
| tout_b | output | 1 | Lane B toggle output |
| irq_match_a | output | 1 | Lane A match interrupt pulse |
| irq_match_b | output | 1 | Lane B match interrupt pulse |
| irq_cap | output | 1 | Capture interrupt pulse |
| cap_val | output | 16 | Captured 16-bit count |

## Verification
The bench runs a compare value of zero, where a lane matches on every tick. An off-by-one compare would instead stretch that period or stall the lane. It rewrites the data register in the middle of a run: a design that loads the new value at once ends the running period early, and its match times move. It drives event and capture pins under each edge mode and sends edges of the wrong polarity. A design with a wrong polarity decode or a missing synchronizer stage would then raise an interrupt nobody expected, or raise it a cycle early. It also pulses the capture pin in 8-bit mode and checks lane B during cascade. A leaky mode gate would give a stray capture or a lane B interrupt there.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    typedef enum logic [0:0] {
        LN_IDLE = 1'b0,
        LN_RUN  = 1'b1
    } lane_state_e;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_CLKSEL = 3'd1;
    localparam logic [2:0] RA_EDGE   = 3'd2;
    localparam logic [2:0] RA_DATLO  = 3'd3;
    localparam logic [2:0] RA_DATHI  = 3'd4;
    localparam logic [2:0] RA_RUN    = 3'd5;

    // mode: 00 rising, 01 falling, 1x either edge
    function automatic logic edge_pick(input logic [1:0] mode,
                                       input logic       cur,
                                       input logic       prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (mode[1])
            return rise | fall;
        else if (mode[0])
            return fall;
        else
            return rise;
    endfunction

endpackage

// File: rtl/mt_edge_det.sv
module mt_edge_det #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    output logic       hit_o
);
    import mtimer_pkg::*;

    logic [SYNC:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else
            sr_q <= {sr_q[SYNC-1:0], pin_i};
    end

    assign hit_o = edge_pick(mode_i, sr_q[SYNC-1], sr_q[SYNC]);

endmodule

// File: rtl/mt_tick_mux.sv
module mt_tick_mux #(
    parameter int SELW = 3
) (
    input  logic [(1<<SELW)-1:0] tick_i,
    input  logic [SELW-1:0]      sel_i,
    input  logic                 alt_i,
    output logic                 tick_o
);
    localparam logic [SELW-1:0] ALT_CODE = '1;

    // the top code is routed to an alternative source
    assign tick_o = (sel_i == ALT_CODE) ? alt_i : tick_i[sel_i];

endmodule

// File: rtl/mt_lane.sv
module mt_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         tick_i,
    input  logic         init_lvl_i,
    input  logic [W-1:0] shadow_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] cmp_o,
    output logic         tout_o,
    output logic         irq_o,
    output logic         idle_o
);
    import mtimer_pkg::*;

    lane_state_e state_q, state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cmp_q;
    logic         tout_q;
    logic         irq_q;
    logic         hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LN_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (start_i) state_d = LN_RUN;
            LN_RUN:  if (stop_i && !start_i) state_d = LN_IDLE;
        endcase
    end

    assign hit = (state_q == LN_RUN) && tick_i && (cnt_q == cmp_q)
                 && !start_i && !stop_i;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            tout_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= hit;
            if (start_i) begin
                cnt_q  <= '0;
                cmp_q  <= shadow_i;
                tout_q <= init_lvl_i;
            end else if (state_q == LN_RUN && !stop_i && tick_i) begin
                if (hit) begin
                    cnt_q  <= '0;
                    cmp_q  <= shadow_i;
                    tout_q <= ~tout_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign count_o = cnt_q;
    assign cmp_o   = cmp_q;
    assign tout_o  = tout_q;
    assign irq_o   = irq_q;
    assign idle_o  = (state_q == LN_IDLE);

endmodule

// File: rtl/mtimer_core.sv
module mtimer_core #(
    parameter int W    = 8,
    parameter int SELW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [W-1:0]         cfg_wdata,
    input  logic [(1<<SELW)-1:0] tick_in,
    input  logic                 evt_pin,
    input  logic                 cap_pin,
    output logic                 tout_a,
    output logic                 tout_b,
    output logic                 irq_match_a,
    output logic                 irq_match_b,
    output logic                 irq_cap,
    output logic [2*W-1:0]       cap_val
);
    import mtimer_pkg::*;

    localparam int NTAP = 1 << SELW;
    localparam int W2   = 2 * W;

    logic            cascade_q, init_a_q, init_b_q;
    logic [SELW-1:0] sel_a_q, sel_b_q;
    logic [1:0]      evt_mode_q, cap_mode_q;
    logic [W-1:0]    dlo_q, dhi_q;

    logic            run_wr, start_a, stop_a, start_b, stop_b;
    logic            evt_hit, cap_hit, tick_a, tick_b;
    logic [W2-1:0]   shadow_a, cnt_a, cmp_a;
    logic [W-1:0]    cnt_b, cmp_b;
    logic            idle_a, idle_b;
    logic [W2-1:0]   cap_q;
    logic            cap_irq_q;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cascade_q  <= 1'b0;
            init_a_q   <= 1'b0;
            init_b_q   <= 1'b0;
            sel_a_q    <= '0;
            sel_b_q    <= '0;
            evt_mode_q <= 2'b00;
            cap_mode_q <= 2'b00;
            dlo_q      <= '0;
            dhi_q      <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                RA_CTRL: begin
                    cascade_q <= cfg_wdata[0];
                    init_a_q  <= cfg_wdata[1];
                    init_b_q  <= cfg_wdata[2];
                end
                RA_CLKSEL: begin
                    sel_a_q <= cfg_wdata[SELW-1:0];
                    sel_b_q <= cfg_wdata[2*SELW-1:SELW];
                end
                RA_EDGE: begin
                    evt_mode_q <= cfg_wdata[1:0];
                    cap_mode_q <= cfg_wdata[3:2];
                end
                RA_DATLO: dlo_q <= cfg_wdata;
                RA_DATHI: dhi_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    assign run_wr  = cfg_we && (cfg_addr == RA_RUN);
    assign start_a = run_wr && cfg_wdata[0];
    assign stop_a  = run_wr && !cfg_wdata[0];
    assign start_b = run_wr && cfg_wdata[1] && !cascade_q;
    assign stop_b  = (run_wr && !cfg_wdata[1]) || cascade_q;

    mt_edge_det #(.SYNC(2)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (evt_pin),
        .mode_i(evt_mode_q),
        .hit_o (evt_hit)
    );

    mt_edge_det #(.SYNC(2)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (cap_pin),
        .mode_i(cap_mode_q),
        .hit_o (cap_hit)
    );

    mt_tick_mux #(.SELW(SELW)) u_mux_a (
        .tick_i(tick_in),
        .sel_i (sel_a_q),
        .alt_i (evt_hit),
        .tick_o(tick_a)
    );

    mt_tick_mux #(.SELW(SELW)) u_mux_b (
        .tick_i(tick_in),
        .sel_i (sel_b_q),
        .alt_i (tick_in[NTAP-1]),
        .tick_o(tick_b)
    );

    assign shadow_a = cascade_q ? {dhi_q, dlo_q} : {{W{1'b0}}, dlo_q};

    mt_lane #(.W(W2)) u_lane_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_a),
        .stop_i    (stop_a),
        .tick_i    (tick_a),
        .init_lvl_i(init_a_q),
        .shadow_i  (shadow_a),
        .count_o   (cnt_a),
        .cmp_o     (cmp_a),
        .tout_o    (tout_a),
        .irq_o     (irq_match_a),
        .idle_o    (idle_a)
    );

    mt_lane #(.W(W)) u_lane_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_b),
        .stop_i    (stop_b),
        .tick_i    (tick_b),
        .init_lvl_i(init_b_q),
        .shadow_i  (dhi_q),
        .count_o   (cnt_b),
        .cmp_o     (cmp_b),
        .tout_o    (tout_b),
        .irq_o     (irq_match_b),
        .idle_o    (idle_b)
    );

    // input capture, 16-bit mode only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q     <= '0;
            cap_irq_q <= 1'b0;
        end else begin
            cap_irq_q <= cap_hit && cascade_q;
            if (cap_hit && cascade_q)
                cap_q <= cnt_a;
        end
    end

    assign cap_val = cap_q;
    assign irq_cap = cap_irq_q;

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cascade_q,
    input logic           start_a,
    input logic           idle_a,
    input logic           idle_b,
    input logic [2*W-1:0] cnt_a,
    input logic [2*W-1:0] cmp_a,
    input logic [W-1:0]   cnt_b,
    input logic [W-1:0]   cmp_b,
    input logic           tout_a,
    input logic           irq_match_a,
    input logic           irq_match_b,
    input logic           irq_cap
);
    AST_COUNT_BOUND_A: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_a |-> cnt_a <= cmp_a);                                    // R2
    AST_COUNT_BOUND_B: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_b |-> cnt_b <= cmp_b);                                    // R2
    AST_IRQ_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match_a |-> $past(!idle_a));                                // R3
    AST_TOGGLE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match_a |-> tout_a != $past(tout_a));                       // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_a && !start_a) |=> $stable(cnt_a));                       // R6
    AST_B_QUIET_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_q && $past(cascade_q)) |-> !irq_match_b);              // R9
    AST_CAP_NEEDS_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cap |-> $past(cascade_q));                                  // R10
endmodule

bind mtimer_core mt_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cascade_q  (cascade_q),
    .start_a    (start_a),
    .idle_a     (idle_a),
    .idle_b     (idle_b),
    .cnt_a      (cnt_a),
    .cmp_a      (cmp_a),
    .cnt_b      (cnt_b),
    .cmp_b      (cmp_b),
    .tout_a     (tout_a),
    .irq_match_a(irq_match_a),
    .irq_match_b(irq_match_b),
    .irq_cap    (irq_cap)
);

// File: tb/sim_mtimer_core.sv
`timescale 1ns/1ps
module sim_mtimer_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  tick_in = 8'h01;
    logic        evt_pin = 1'b0;
    logic        cap_pin = 1'b0;
    logic        tout_a, tout_b, irq_match_a, irq_match_b, irq_cap;
    logic [15:0] cap_val;

    typedef struct {
        int    cyc;
        int    val;
        string req;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];
    exp_t qc[$];
    exp_t mon_e;

    int  cyc = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mtimer_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .tick_in    (tick_in),
        .evt_pin    (evt_pin),
        .cap_pin    (cap_pin),
        .tout_a     (tout_a),
        .tout_b     (tout_b),
        .irq_match_a(irq_match_a),
        .irq_match_b(irq_match_b),
        .irq_cap    (irq_cap),
        .cap_val    (cap_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmp_item(input string src, input exp_t e, input int val);
        n_cmp++;
        if (e.cyc != cyc || e.val != val) begin
            n_bad++;
            $display("FAIL %s %s: actual cycle %0d value %0h, expected cycle %0d value %0h",
                     e.req, src, cyc, val, e.cyc, e.val);
        end
    endtask

    task automatic stray(input string src);
        n_cmp++;
        n_bad++;
        $display("FAIL R6/R8/R9/R10 %s: actual interrupt at cycle %0d, expected none", src, cyc);
    endtask

    // monitor: pops expected items as interrupts appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (irq_match_a) begin
                if (qa.size() == 0) stray("lane A");
                else begin mon_e = qa.pop_front(); cmp_item("lane A", mon_e, int'(tout_a)); end
            end
            if (irq_match_b) begin
                if (qb.size() == 0) stray("lane B");
                else begin mon_e = qb.pop_front(); cmp_item("lane B", mon_e, int'(tout_b)); end
            end
            if (irq_cap) begin
                if (qc.size() == 0) stray("capture");
                else begin mon_e = qc.pop_front(); cmp_item("capture", mon_e, int'(cap_val)); end
            end
        end
    end

    // caller is at a negedge; the write is taken on the next edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic push(input int which, input int c, input int v, input string r);
        exp_t e;
        e.cyc = c; e.val = v; e.req = r;
        if (which == 0) qa.push_back(e);
        else if (which == 1) qb.push_back(e);
        else qc.push_back(e);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all R): actual hang, expected completion");
        summary();
    end

    initial begin
        int s, c, lvl, last_cap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tout_a", int'(tout_a), 0);
        chk("R1 tout_b", int'(tout_b), 0);
        chk("R1 irqs", int'({irq_match_a, irq_match_b, irq_cap}), 0);
        chk("R1 cap_val", int'(cap_val), 0);

        // R2 R3 R4: D=5, start low, then stop (R6)
        wr(3'd3, 8'd5);
        wr(3'd5, 8'h01);
        s = cyc;
        for (int n = 1; n <= 3; n++) push(0, s + 6*n, n % 2, "R2/R3/R4");
        wait_until(s + 18);
        wr(3'd5, 8'h00);
        repeat (20) @(negedge clk);
        chk("R6 hold after stop", int'(tout_a), 1);
        chk("R2 queue A drained", qa.size(), 0);

        // R2 boundary D=0, R5 initial level high
        wr(3'd0, 8'h02);
        wr(3'd3, 8'd0);
        wr(3'd5, 8'h01);
        s = cyc;
        chk("R5 initial high", int'(tout_a), 1);
        for (int n = 1; n <= 4; n++) push(0, s + n, (n % 2 == 1) ? 0 : 1, "R2 D=0");
        wait_until(s + 4);
        wr(3'd5, 8'h00);
        repeat (5) @(negedge clk);
        chk("R2 D=0 drained", qa.size(), 0);

        // R11 data change mid-run
        wr(3'd0, 8'h00);
        wr(3'd3, 8'd5);
        wr(3'd5, 8'h01);
        s = cyc;
        push(0, s + 6, 1, "R11");
        push(0, s + 12, 0, "R11");
        push(0, s + 15, 1, "R11");
        push(0, s + 18, 0, "R11");
        wait_until(s + 6);
        wr(3'd3, 8'd2);
        wait_until(s + 18);
        wr(3'd5, 8'h00);
        repeat (5) @(negedge clk);
        chk("R11 drained", qa.size(), 0);

        // both lanes together, lane B starts high (R5)
        wr(3'd0, 8'h04);
        wr(3'd3, 8'd1);
        wr(3'd4, 8'd3);
        wr(3'd5, 8'h03);
        s = cyc;
        chk("R5 lane B initial high", int'(tout_b), 1);
        for (int n = 1; n <= 6; n++) push(0, s + 2*n, n % 2, "R4 lane A");
        for (int n = 1; n <= 3; n++) push(1, s + 4*n, (n % 2 == 1) ? 0 : 1, "R4 lane B");
        wait_until(s + 12);
        wr(3'd5, 8'h00);
        repeat (5) @(negedge clk);
        chk("R4 lanes drained", qa.size() + qb.size(), 0);

        // R7 event clock, rising edges, D=2
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h07);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'd2);
        wr(3'd5, 8'h01);
        lvl = 0;
        for (int j = 1; j <= 6; j++) begin
            evt_pin = 1'b1;
            if (j % 3 == 0) begin lvl ^= 1; push(0, cyc + 3, lvl, "R7 event"); end
            repeat (4) @(negedge clk);
            evt_pin = 1'b0;
            repeat (4) @(negedge clk);
        end
        wr(3'd5, 8'h00);
        // R8 both edges, D=1
        wr(3'd2, 8'h02);
        wr(3'd3, 8'd1);
        wr(3'd5, 8'h01);
        lvl = 0;
        for (int j = 1; j <= 4; j++) begin
            evt_pin = ~evt_pin;
            if (j % 2 == 0) begin lvl ^= 1; push(0, cyc + 3, lvl, "R8 both"); end
            repeat (4) @(negedge clk);
        end
        wr(3'd5, 8'h00);
        // R8 falling only, D=0
        wr(3'd2, 8'h01);
        wr(3'd3, 8'd0);
        wr(3'd5, 8'h01);
        lvl = 0;
        for (int j = 1; j <= 2; j++) begin
            evt_pin = 1'b1;
            repeat (4) @(negedge clk);
            evt_pin = 1'b0;
            lvl ^= 1;
            push(0, cyc + 3, lvl, "R8 falling");
            repeat (4) @(negedge clk);
        end
        wr(3'd5, 8'h00);
        repeat (5) @(negedge clk);
        chk("R8 event drained", qa.size(), 0);

        // R7 quiet tap: code 3 with tick_in[3] low never counts
        wr(3'd1, 8'h03);
        wr(3'd3, 8'd0);
        wr(3'd5, 8'h01);
        repeat (40) @(negedge clk);
        wr(3'd5, 8'h00);
        chk("R7 idle tap output", int'(tout_a), 0);

        // R9 cascade 16-bit, compare 0x0104
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h05);
        wr(3'd3, 8'h04);
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h03);
        s = cyc;
        push(0, s + 261, 1, "R9 cascade");
        push(0, s + 522, 0, "R9 cascade");
        wait_until(s + 522);
        wr(3'd5, 8'h00);
        repeat (5) @(negedge clk);
        chk("R9 lane B held", int'(tout_b), 0);
        chk("R9 drained", qa.size() + qb.size(), 0);

        // R10 capture in cascade mode
        wr(3'd0, 8'h01);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        wr(3'd2, 8'h00);
        wr(3'd5, 8'h01);
        s = cyc;
        repeat (10) @(negedge clk);
        c = cyc; cap_pin = 1'b1; push(2, c + 3, c + 2 - s, "R10 rising");
        repeat (10) @(negedge clk);
        cap_pin = 1'b0;
        repeat (10) @(negedge clk);
        wr(3'd2, 8'h04);
        repeat (5) @(negedge clk);
        cap_pin = 1'b1;
        repeat (10) @(negedge clk);
        c = cyc; cap_pin = 1'b0; push(2, c + 3, c + 2 - s, "R8 cap falling");
        repeat (10) @(negedge clk);
        wr(3'd2, 8'h08);
        repeat (5) @(negedge clk);
        c = cyc; cap_pin = 1'b1; push(2, c + 3, c + 2 - s, "R8 cap both");
        repeat (10) @(negedge clk);
        c = cyc; cap_pin = 1'b0; push(2, c + 3, c + 2 - s, "R8 cap both");
        last_cap = c + 2 - s;
        repeat (10) @(negedge clk);
        wr(3'd5, 8'h00);
        // 8-bit mode: capture pin ignored
        wr(3'd0, 8'h00);
        repeat (3) @(negedge clk);
        cap_pin = 1'b1;
        repeat (10) @(negedge clk);
        cap_pin = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 capture ignored in 8-bit", int'(cap_val), last_cap);
        chk("R10 drained", qc.size(), 0);

        summary();
    end

endmodule